// File: doc/BRIEF.md
# Off-Edge Sampled Charge PWM

This block drives the switch of a solar charger with an 8-bit pulse-width signal and tells an external ADC when to convert. The period has 256 steps, each set by a one-cycle `tick` enable; with 32 us steps a period lasts about 8.2 ms, so there are about 122 periods per second. The output works in active-low fashion. The step counter wrap is where the switch turns off, and it turns on again later in the period. One ADC start pulse comes in every period, one step after that off edge. The battery voltage is therefore read while no charge current flows in the lead. Without this timing the drop across the wire would spoil the reading.

Each start pulse carries a flag that says whether the reading is accurate. It is accurate only when the switch stays off long enough to cover the start delay and a 64 us conversion guard. At duty 254 or 255 the off time is too short, so the flag is cleared. In bulk charge the switch is held fully on. Once in a programmable number of periods (610 by default, about 5 s) the block opens a short forced off window of about 1% of a period, so that the display still gets a good reading. Duty and bulk mode are taken only at period boundaries.

Top module: `pwm_offedge_sampler`

## Requirements
- R1: While `rst_n` is low and just after release, `sw_on_n` is 1 (switch off), `adc_start` is 0 and `sample_acc` is 0.
- R2: The step counter advances once per `tick`, and a period is 256 steps. For a latched duty D outside bulk mode, `sw_on_n` is 1 for the first 256-D steps of the period, counted from the wrap, and 0 for the remaining D steps. D=0 keeps the switch off for the whole period.
- R3: A change of `duty` or `bulk` takes effect only at the next period boundary, which is the tick that wraps step 255 to step 0.
- R4: `adc_start` is high for exactly one clock cycle per period. That cycle is the one right after the tick that moves the counter from step 0 to step 1, which is one step after the off edge.
- R5: `sample_acc` is updated in the same cycle as each `adc_start` pulse and then holds. It is 1 when the off interval of the current period is at least 3 steps (start delay of 1 plus a guard of 2), so it is 1 for D at most 253 and 0 for D of 254 or 255.
- R6: In bulk mode, outside a forced window, `sw_on_n` is 0 for all 256 steps and `sample_acc` reads 0 at the pulse.
- R7: Period boundaries are counted from reset. When `bulk` is high at boundary number k·BULK_PERIODS, the next period is a forced window. In that period `sw_on_n` is 1 for the first 3 steps and 0 afterwards, and `sample_acc` reads 1.
- R8: In cycles without `tick` the step count, the switch state and the latched settings do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle step enable |
| duty | input | 8 | Requested on-steps per period |
| bulk | input | 1 | Bulk charge: hold switch fully on |
| sw_on_n | output | 1 | Switch drive, 0 = switch conducting |
| adc_start | output | 1 | One-cycle ADC conversion start |
| sample_acc | output | 1 | 1 = current reading taken with switch off long enough |

## Verification
The block is run with fixed duties in the middle of the range, at zero, at 253 and at 254/255. This separates the accurate-flag threshold from plain off-time generation. Bulk runs long enough to cross several forced windows, which shows whether the period count and the forced width are right and whether the flag is raised only in those windows. Random stretches with gapped ticks and duty or bulk changes in the middle of a period check that settings are latched only at the boundary and that nothing moves between ticks.

// File: rtl/pwm_offedge_sampler.sv
module pwm_offedge_sampler #(
  parameter int STEP_W       = 8,
  parameter int GUARD_STEPS  = 2,
  parameter int FORCE_STEPS  = 3,
  parameter int BULK_PERIODS = 610
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] duty,
  input  logic              bulk,
  output logic              sw_on_n,
  output logic              adc_start,
  output logic              sample_acc
);
  localparam int STEPS   = 1 << STEP_W;
  localparam int MIN_OFF = 1 + GUARD_STEPS;
  localparam int PC_W    = $clog2(BULK_PERIODS + 1);

  logic [STEP_W-1:0] step;
  logic [STEP_W:0]   off_len, next_off;
  logic [PC_W-1:0]   per_cnt;
  logic              period_acc, forced_q, bulk_q, forced_next, wrap;

  assign wrap        = tick && (step == {STEP_W{1'b1}});
  assign forced_next = bulk && (per_cnt == PC_W'(BULK_PERIODS - 1));
  assign next_off    = bulk ? (forced_next ? (STEP_W+1)'(FORCE_STEPS) : '0)
                            : (STEP_W+1)'(STEPS) - {1'b0, duty};
  assign sw_on_n     = ({1'b0, step} < off_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= '0;
      off_len    <= (STEP_W+1)'(STEPS);
      period_acc <= 1'b1;
      per_cnt    <= '0;
      forced_q   <= 1'b0;
      bulk_q     <= 1'b0;
      adc_start  <= 1'b0;
      sample_acc <= 1'b0;
    end else begin
      adc_start <= tick && (step == '0);
      if (tick && step == '0) sample_acc <= period_acc;
      if (tick) step <= step + 1'b1;
      if (wrap) begin
        off_len    <= next_off;
        period_acc <= (next_off >= (STEP_W+1)'(MIN_OFF));
        per_cnt    <= (per_cnt == PC_W'(BULK_PERIODS - 1)) ? '0 : per_cnt + 1'b1;
        forced_q   <= forced_next;
        bulk_q     <= bulk;
      end
    end
  end

  p_start_at_step1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> step == STEP_W'(1));
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  p_acc_needs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && sample_acc) |-> (sw_on_n && off_len >= (STEP_W+1)'(MIN_OFF)));
  p_bulk_held_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_q && !forced_q) |-> !sw_on_n);
  p_forced_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> off_len == (STEP_W+1)'(FORCE_STEPS));
  p_load_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(off_len));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(step) && $stable(sw_on_n)));
endmodule

// File: tb/test_pwm_offedge_sampler.sv
`timescale 1ns/1ps
module test_pwm_offedge_sampler;
  localparam int P = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bulk = 1'b0;
  logic [7:0] duty = 8'd0;
  logic sw_on_n, adc_start, sample_acc;
  int checks = 0, errors = 0;
  bit done = 0;

  int m_cnt = 0, m_off = 256, m_b = 0;
  bit m_pacc = 1, m_start = 0, m_sacc = 0, m_forced = 0, m_bulkq = 0;

  pwm_offedge_sampler #(.BULK_PERIODS(P)) i_pwm_offedge_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick), .duty(duty), .bulk(bulk),
    .sw_on_n(sw_on_n), .adc_start(adc_start), .sample_acc(sample_acc));

  always #10 clk = ~clk;

  function automatic int exp_off(input int d, input bit b, input bit f);
    if (b) return f ? 3 : 0;
    return 256 - d;
  endfunction

  function automatic bit exp_acc(input int off);
    return off >= 3;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic [7:0] d, input logic b);
    @(negedge clk);
    chk(m_forced ? "R7 switch" : (m_bulkq ? "R6 switch" : "R2/R3/R8 switch"),
        sw_on_n, m_cnt < m_off);
    chk("R4 start", adc_start, m_start);
    chk(m_forced ? "R7 acc" : (m_bulkq ? "R6 acc" : "R5 acc"), sample_acc, m_sacc);
    tick = t; duty = d; bulk = b;
    m_start = t && (m_cnt == 0);
    if (m_start) m_sacc = m_pacc;
    if (t) begin
      if (m_cnt == 255) begin
        m_b++;
        m_forced = b && (m_b % P == 0);
        m_bulkq  = b;
        m_off    = exp_off(d, b, m_forced);
        m_pacc   = exp_acc(m_off);
      end
      m_cnt = (m_cnt + 1) % 256;
    end
  endtask

  task automatic run_periods(input int n, input logic [7:0] d, input logic b);
    for (int i = 0; i < n * 256; i++) cyc(1'b1, d, b);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 switch", sw_on_n, 1'b1);
    chk("R1 start", adc_start, 1'b0);
    chk("R1 acc", sample_acc, 1'b0);
    rst_n = 1'b1;
    run_periods(2, 8'd128, 1'b0);
    run_periods(2, 8'd253, 1'b0);
    run_periods(2, 8'd254, 1'b0);
    run_periods(2, 8'd255, 1'b0);
    run_periods(2, 8'd0, 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b1, 8'd40, 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b0, 8'd200, 1'b0);   // R8 idle, R3 mid-period change
    run_periods(2, 8'd200, 1'b0);
    run_periods(10, 8'd200, 1'b1);                           // R6/R7 bulk with forced windows
    begin
      logic [7:0] d = 8'd100;
      logic b = 1'b0;
      for (int i = 0; i < 60000; i++) begin
        if ($urandom % 400 == 0) begin
          case ($urandom % 6)
            0: d = 8'd254;
            1: d = 8'd255;
            2: d = 8'd253;
            3: d = 8'd0;
            default: d = 8'($urandom);
          endcase
        end
        if ($urandom % 3000 == 0) b = ~b;
        cyc(($urandom % 4) != 0, d, b);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule